// File: doc/BRIEF.md
# Interpolated Degamma Curve Stage

This block linearises one colour channel of a pixel stream. Each valid input sample is a signed fixed-point value with 24 fractional bits. The block looks its magnitude up in a programmable curve of 131 points, interpolates linearly between the two bracketing points and puts the sign back on the result. An integrator who needs three channels places three copies and loads each with the same curve.

The curve is loaded through a small index/data port. An index write with the step flag clear loads a new table index and puts the port in fixed mode (transition LOAD_FIXED, into state PM_FIXED). An index write with the step flag set leaves the index as it is and switches to step mode (transition ENTER_STEP, into state PM_STEP). In PM_STEP every data write stores an entry and advances the index (transition ADVANCE). In PM_FIXED data writes leave the index alone (transition HOLD). To load a whole table, software writes index 0 with the flag clear, then writes the flag, then streams 131 data words. The read port always shows the entry at the current index.

The interpolation datapath has three register stages. The segment is selected and the table is read in the first stage. The slope term is multiplied in the second. The base is added and the sign applied in the third.

Top module: `degamma_curve_unit`

## Requirements
- R1: After reset, the table holds an identity ramp. Entry i equals i·2^17 for i ≤ 128. Entry 129 equals 2^25 and entry 130 equals 2^26.
- R2: A data write to an entry below 128 keeps only the low 24 bits of the written word; the top 3 bits read back as zero. Entries 128 to 130 keep all 27 bits.
- R3: An index write with the step flag clear loads the index and selects fixed mode. The read port then returns the entry at that index.
- R4: An index write with the step flag set does not change the index and selects step mode. In step mode each accepted data write stores at the current index and then advances the index by one. The index wraps from 130 to 0.
- R5: In fixed mode a data write does not move the index.
- R6: The result valid flag repeats the input valid flag exactly three clock cycles later, and is low after reset.
- R7: For magnitudes below 1.0 (2^24), the segment k is bits 23:17 and the weight w is bits 16:0. The result is e[k] + floor((e[k+1]−e[k])·w / 2^17).
- R8: A magnitude of exactly 1.0 gives e[128]. Magnitudes in [1.0, 2.0) interpolate from e[128] to e[129] using bits 23:0 over 2^24 as the weight. Magnitudes in [2.0, 4.0) interpolate from e[129] to e[130] using bits 24:1 over 2^24 as the weight.
- R9: Magnitudes of 4.0 (2^26) and above give e[130].
- R10: Inputs and outputs are 28-bit two's complement. A negative input returns the negated result for its magnitude.
- R11: A data write takes effect for a pixel presented in the very next cycle.
- R12: While the index is above 130, the read port returns zero, and data writes change no entry and do not move the index.
- R13: When an index write and a data write arrive in the same cycle, the index write is applied and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input sample valid |
| pix_in | input | 28 | Signed input sample, 24 fractional bits |
| res_valid | output | 1 | Result valid |
| res_out | output | 28 | Signed result, 24 fractional bits |
| lut_idx_we | input | 1 | Index register write strobe |
| lut_idx_step | input | 1 | Step flag for the index write |
| lut_idx_val | input | 8 | Index value for the index write |
| lut_dat_we | input | 1 | Data register write strobe |
| lut_dat_val | input | 27 | Entry value, 3 integer and 24 fractional bits |
| lut_rdata | output | 27 | Entry at the current index, zero when out of range |

## Verification
The reset identity ramp maps every magnitude below 4.0 onto itself. Vectors spread over the four magnitude ranges therefore expose segment or weight slicing errors as exact numeric deviations. An odd value in the [2.0, 4.0) range shows that the halved weight drops the least significant bit. A loaded non-linear curve with unequal point spacing then separates a correct interpolation from one that reads the wrong pair of entries. Negative inputs, the most negative code and the exact 1.0 and 4.0 boundaries cover reflection, the extended entries and saturation.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
    localparam int FRAC_W   = 24;
    localparam int INT_W    = 3;
    localparam int ENT_W    = FRAC_W + INT_W;
    localparam int PIX_W    = ENT_W + 1;
    localparam int SEG_BITS = 7;
    localparam int N_SEG    = 1 << SEG_BITS;
    localparam int N_EXT    = 3;
    localparam int N_ENT    = N_SEG + N_EXT;
    localparam int IDX_W    = $clog2(N_ENT);
    localparam int WGT_LO_W = FRAC_W - SEG_BITS;
    localparam int PROD_W   = (ENT_W + 1) + (FRAC_W + 1);

    typedef enum logic {
        PM_FIXED = 1'b0,
        PM_STEP  = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0]  lo;
        logic [IDX_W-1:0]  hi;
        logic [FRAC_W-1:0] wgt;
        logic              neg;
    } seg_sel_t;

    function automatic logic [ENT_W-1:0] dgc_reset_entry(input int i);
        if (i <= N_SEG) return ENT_W'(i) << WGT_LO_W;
        else            return ENT_W'(1) << (FRAC_W + i - N_SEG);
    endfunction

    function automatic logic [ENT_W-1:0] dgc_keep_mask(input logic [IDX_W-1:0] i);
        if (i < IDX_W'(N_SEG)) return {{INT_W{1'b0}}, {FRAC_W{1'b1}}};
        else                   return {ENT_W{1'b1}};
    endfunction
endpackage

// File: rtl/dgc_seg_sel.sv
module dgc_seg_sel
    import dgc_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    output seg_sel_t         sel
);
    localparam int IP_W = PIX_W - FRAC_W;

    logic [PIX_W-1:0] mag;
    logic [IP_W-1:0]  ipart;

    always_comb begin
        sel.neg = pix[PIX_W-1];
        mag     = sel.neg ? (~pix + PIX_W'(1)) : pix;
        ipart   = mag[PIX_W-1:FRAC_W];
        sel.lo  = '0;
        sel.hi  = '0;
        sel.wgt = '0;
        if (ipart == IP_W'(0)) begin
            sel.lo  = IDX_W'(mag[FRAC_W-1:WGT_LO_W]);
            sel.hi  = sel.lo + IDX_W'(1);
            sel.wgt = {mag[WGT_LO_W-1:0], {SEG_BITS{1'b0}}};
        end else if (ipart == IP_W'(1)) begin
            sel.lo  = IDX_W'(N_SEG);
            sel.hi  = IDX_W'(N_SEG + 1);
            sel.wgt = mag[FRAC_W-1:0];
        end else if (ipart < IP_W'(4)) begin
            sel.lo  = IDX_W'(N_SEG + 1);
            sel.hi  = IDX_W'(N_SEG + 2);
            sel.wgt = mag[FRAC_W:1];
        end else begin
            sel.lo  = IDX_W'(N_SEG + 2);
            sel.hi  = IDX_W'(N_SEG + 2);
            sel.wgt = '0;
        end
    end
endmodule

// File: rtl/dgc_table_port.sv
module dgc_table_port
    import dgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              idx_step,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic              dat_we,
    input  logic [ENT_W-1:0]  dat_val,
    input  logic [IDX_W-1:0]  rd_lo,
    input  logic [IDX_W-1:0]  rd_hi,
    output logic [ENT_W-1:0]  ent_lo,
    output logic [ENT_W-1:0]  ent_hi,
    output logic [ENT_W-1:0]  rdata,
    output logic [IDX_W-1:0]  cur_idx,
    output port_mode_e        mode
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    port_mode_e       mode_q, mode_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             wr_en;
    logic             in_range;
    logic [ENT_W-1:0] tbl [N_ENT];

    assign in_range = (idx_q <= LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_FIXED;
            idx_q  <= '0;
        end else begin
            mode_q <= mode_d;
            idx_q  <= idx_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        idx_d  = idx_q;
        wr_en  = 1'b0;
        if (idx_we) begin
            if (idx_step) begin
                mode_d = PM_STEP;
            end else begin
                mode_d = PM_FIXED;
                idx_d  = idx_val;
            end
        end else if (dat_we && in_range) begin
            wr_en = 1'b1;
            unique case (mode_q)
                PM_STEP:  idx_d = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
                PM_FIXED: idx_d = idx_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) tbl[i] <= dgc_reset_entry(i);
        end else if (wr_en) begin
            tbl[idx_q] <= dat_val & dgc_keep_mask(idx_q);
        end
    end

    always_comb begin
        rdata   = in_range ? tbl[idx_q] : '0;
        ent_lo  = tbl[rd_lo];
        ent_hi  = tbl[rd_hi];
        cur_idx = idx_q;
        mode    = mode_q;
    end
endmodule

// File: rtl/dgc_interp_pipe.sv
module dgc_interp_pipe
    import dgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_neg,
    input  logic [ENT_W-1:0]  in_a,
    input  logic [ENT_W-1:0]  in_b,
    input  logic [FRAC_W-1:0] in_w,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    logic              v1, n1, v2, n2;
    logic [ENT_W-1:0]  a1, b1, a2;
    logic [FRAC_W-1:0] w1;
    logic signed [ENT_W:0]   diff;
    logic signed [FRAC_W:0]  wsg;
    logic signed [PIX_W-1:0] d2;
    logic signed [PIX_W-1:0] sum;

    assign diff = $signed({1'b0, b1}) - $signed({1'b0, a1});
    assign wsg  = $signed({1'b0, w1});
    assign sum  = $signed({1'b0, a2}) + d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; n1 <= 1'b0; a1 <= '0; b1 <= '0; w1 <= '0;
            v2 <= 1'b0; n2 <= 1'b0; a2 <= '0; d2 <= '0;
            out_valid <= 1'b0; out_pix <= '0;
        end else begin
            v1 <= in_valid;
            n1 <= in_neg;
            a1 <= in_a;
            b1 <= in_b;
            w1 <= in_w;
            v2 <= v1;
            n2 <= n1;
            a2 <= a1;
            d2 <= PIX_W'((PROD_W'(diff) * PROD_W'(wsg)) >>> FRAC_W);
            out_valid <= v2;
            out_pix   <= n2 ? (~sum + PIX_W'(1)) : sum;
        end
    end
endmodule

// File: rtl/degamma_curve_unit.sv
module degamma_curve_unit
    import dgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              res_valid,
    output logic [PIX_W-1:0]  res_out,
    input  logic              lut_idx_we,
    input  logic              lut_idx_step,
    input  logic [IDX_W-1:0]  lut_idx_val,
    input  logic              lut_dat_we,
    input  logic [ENT_W-1:0]  lut_dat_val,
    output logic [ENT_W-1:0]  lut_rdata
);
    seg_sel_t         sel;
    logic [ENT_W-1:0] ent_lo, ent_hi;
    logic [IDX_W-1:0] cur_idx;
    port_mode_e       port_mode;

    dgc_seg_sel u_sel (
        .pix (pix_in),
        .sel (sel)
    );

    dgc_table_port u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (lut_idx_we),
        .idx_step (lut_idx_step),
        .idx_val  (lut_idx_val),
        .dat_we   (lut_dat_we),
        .dat_val  (lut_dat_val),
        .rd_lo    (sel.lo),
        .rd_hi    (sel.hi),
        .ent_lo   (ent_lo),
        .ent_hi   (ent_hi),
        .rdata    (lut_rdata),
        .cur_idx  (cur_idx),
        .mode     (port_mode)
    );

    dgc_interp_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid),
        .in_neg    (sel.neg),
        .in_a      (ent_lo),
        .in_b      (ent_hi),
        .in_w      (sel.wgt),
        .out_valid (res_valid),
        .out_pix   (res_out)
    );
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker
    import dgc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_in,
    input logic             res_valid,
    input logic [PIX_W-1:0] res_out,
    input logic             lut_idx_we,
    input logic             lut_idx_step,
    input logic [IDX_W-1:0] lut_idx_val,
    input logic             lut_dat_we,
    input logic [ENT_W-1:0] lut_rdata,
    input logic [IDX_W-1:0] cur_idx,
    input port_mode_e       port_mode
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (res_valid == $past(pix_valid, 3)));

    p_neg_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(pix_valid && pix_in[PIX_W-1], 3))
        |-> (res_out[PIX_W-1] || res_out == '0));

    p_pos_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(pix_valid && !pix_in[PIX_W-1], 3))
        |-> !res_out[PIX_W-1]);

    p_idx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_idx_we && !lut_idx_step)
        |=> (cur_idx == $past(lut_idx_val) && port_mode == PM_FIXED));

    p_step_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_idx_we && lut_idx_step)
        |=> ($stable(cur_idx) && port_mode == PM_STEP));

    p_step_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lut_idx_we && lut_dat_we && port_mode == PM_STEP && cur_idx < LAST)
        |=> (cur_idx == $past(cur_idx) + IDX_W'(1)));

    p_fixed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lut_idx_we && port_mode == PM_FIXED) |=> $stable(cur_idx));

    p_oor_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx > LAST) |-> (lut_rdata == '0));

    p_oor_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!lut_idx_we && cur_idx > LAST) |=> $stable(cur_idx));
endmodule

bind degamma_curve_unit dgc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_in       (pix_in),
    .res_valid    (res_valid),
    .res_out      (res_out),
    .lut_idx_we   (lut_idx_we),
    .lut_idx_step (lut_idx_step),
    .lut_idx_val  (lut_idx_val),
    .lut_dat_we   (lut_dat_we),
    .lut_rdata    (lut_rdata),
    .cur_idx      (cur_idx),
    .port_mode    (port_mode)
);

// File: tb/test_degamma_curve_unit.sv
`timescale 1ns/1ps
module test_degamma_curve_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [27:0] pix_in = '0;
    logic        res_valid;
    logic [27:0] res_out;
    logic        lut_idx_we = 1'b0;
    logic        lut_idx_step = 1'b0;
    logic [7:0]  lut_idx_val = '0;
    logic        lut_dat_we = 1'b0;
    logic [26:0] lut_dat_val = '0;
    logic [26:0] lut_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [26:0] mdl [131];

    always #2.5 clk = ~clk;

    degamma_curve_unit i_degamma_curve_unit (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
        .res_valid(res_valid), .res_out(res_out),
        .lut_idx_we(lut_idx_we), .lut_idx_step(lut_idx_step), .lut_idx_val(lut_idx_val),
        .lut_dat_we(lut_dat_we), .lut_dat_val(lut_dat_val), .lut_rdata(lut_rdata)
    );

    localparam int NV = 14;
    localparam logic [27:0] V_IN [NV] = '{
        28'h0000000, 28'h0000001, 28'h0012345, 28'h0FFFFFF, 28'h1000000,
        28'h1800001, 28'h2000000, 28'h2ABCDEF, 28'h3FFFFFF, 28'h4000000,
        28'h7FFFFFF, 28'hFFFFFFB, 28'hD543211, 28'h8000000};
    localparam logic [27:0] V_EXP [NV] = '{
        28'h0000000, 28'h0000001, 28'h0012345, 28'h0FFFFFF, 28'h1000000,
        28'h1800001, 28'h2000000, 28'h2ABCDEE, 28'h3FFFFFE, 28'h4000000,
        28'h4000000, 28'hFFFFFFB, 28'hD543212, 28'hC000000};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic idx_write(input logic [7:0] v, input logic step);
        @(negedge clk);
        lut_idx_we = 1'b1; lut_idx_val = v; lut_idx_step = step;
        @(negedge clk);
        lut_idx_we = 1'b0; lut_idx_step = 1'b0;
    endtask

    task automatic dat_write(input logic [26:0] v);
        @(negedge clk);
        lut_dat_we = 1'b1; lut_dat_val = v;
        @(negedge clk);
        lut_dat_we = 1'b0;
    endtask

    task automatic run_pixel(input logic [27:0] x, output logic [27:0] y,
                             output logic v_early, output logic v_on, output logic v_after);
        @(negedge clk);
        pix_valid = 1'b1; pix_in = x;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        v_early = res_valid;
        @(negedge clk);
        v_on = res_valid; y = res_out;
        @(negedge clk);
        v_after = res_valid;
    endtask

    function automatic logic [27:0] model(input logic [27:0] x);
        logic [27:0] m;
        int lo, hi;
        longint w, a, b, r;
        m = x[27] ? (~x + 28'd1) : x;
        if (m < 28'h1000000) begin
            lo = int'(m[23:17]); hi = lo + 1; w = longint'(m[16:0]) << 7;
        end else if (m < 28'h2000000) begin
            lo = 128; hi = 129; w = longint'(m[23:0]);
        end else if (m < 28'h4000000) begin
            lo = 129; hi = 130; w = longint'(m[24:1]);
        end else begin
            lo = 130; hi = 130; w = 0;
        end
        a = longint'(mdl[lo]); b = longint'(mdl[hi]);
        r = a + (((b - a) * w) >>> 24);
        return x[27] ? 28'(-r) : 28'(r);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [27:0] y;
        logic ve, vo, va;
        logic mono;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset valid", 32'(res_valid), 0);
        chk("R6 reset data", 32'(res_out), 0);

        // R1: reset ramp through readback
        idx_write(8'd0, 1'b0);   chk("R1 e0", 32'(lut_rdata), 0);
        idx_write(8'd1, 1'b0);   chk("R1 e1", 32'(lut_rdata), 32'h20000);
        idx_write(8'd64, 1'b0);  chk("R1 e64", 32'(lut_rdata), 32'h800000);
        idx_write(8'd128, 1'b0); chk("R1 e128", 32'(lut_rdata), 32'h1000000);
        idx_write(8'd129, 1'b0); chk("R1 e129", 32'(lut_rdata), 32'h2000000);
        idx_write(8'd130, 1'b0); chk("R1 e130", 32'(lut_rdata), 32'h4000000);

        // vector table against the identity ramp (R7 R8 R9 R10, timing R6)
        for (int i = 0; i < NV; i++) begin
            run_pixel(V_IN[i], y, ve, vo, va);
            chk("R7 R8 R9 R10 vector", 32'(y), 32'(V_EXP[i]));
            if (i == 0) begin
                chk("R6 not yet valid", 32'(ve), 0);
                chk("R6 valid on third", 32'(vo), 1);
                chk("R6 single pulse", 32'(va), 0);
            end
        end

        // load a non-linear curve in step mode (R3 R4)
        idx_write(8'd0, 1'b0);
        idx_write(8'd77, 1'b1);
        for (int i = 0; i < 131; i++) begin
            logic [26:0] v;
            if (i < 128)       v = 27'((i * i) << 10);
            else if (i == 128) v = 27'h1000000;
            else if (i == 129) v = 27'h3000000;
            else               v = 27'h7FFFFFF;
            mdl[i] = v;
            dat_write(v);
        end
        chk("R4 wrapped to 0", 32'(lut_rdata), 32'(mdl[0]));
        dat_write(27'h5);
        mdl[0] = 27'h5;
        chk("R4 advanced to 1", 32'(lut_rdata), 32'(mdl[1]));
        idx_write(8'd0, 1'b0);
        chk("R3 readback e0", 32'(lut_rdata), 32'h5);
        idx_write(8'd7, 1'b0);
        idx_write(8'd50, 1'b1);
        chk("R4 flag keeps index", 32'(lut_rdata), 32'(mdl[7]));
        idx_write(8'd130, 1'b0);
        chk("R3 readback e130", 32'(lut_rdata), 32'(mdl[130]));

        mono = 1'b1;
        for (int i = 1; i < 131; i++) if (mdl[i] < mdl[i-1]) mono = 1'b0;
        chk("R7 table non-decreasing", 32'(mono), 1);

        for (int i = 0; i < 10; i++) begin
            logic [27:0] x;
            case (i)
                0: x = 28'h0000000; 1: x = 28'h0ABCDEF; 2: x = 28'h0FFFFFF;
                3: x = 28'h1000000; 4: x = 28'h1234567; 5: x = 28'h2800001;
                6: x = 28'h5000000; 7: x = 28'hF543211; 8: x = 28'hD000000;
                default: x = 28'h0020000;
            endcase
            run_pixel(x, y, ve, vo, va);
            chk("R7 R8 R9 R10 curve", 32'(y), 32'(model(x)));
        end

        // R2 masking of low entries
        idx_write(8'd5, 1'b0);
        dat_write(27'h7ABCDEF);
        chk("R2 low entry masked", 32'(lut_rdata), 32'hABCDEF);
        idx_write(8'd129, 1'b0);
        dat_write(27'h7ABCDEF);
        chk("R2 ext entry full", 32'(lut_rdata), 32'h7ABCDEF);

        // R5 fixed mode holds index
        idx_write(8'd6, 1'b0);
        dat_write(27'h200);
        dat_write(27'h300);
        chk("R5 same entry", 32'(lut_rdata), 32'h300);
        idx_write(8'd7, 1'b0);
        chk("R5 neighbour untouched", 32'(lut_rdata), 32'(mdl[7]));

        // R11 write then pixel in the next cycle
        idx_write(8'd10, 1'b0);
        @(negedge clk);
        lut_dat_we = 1'b1; lut_dat_val = 27'h0400000;
        @(negedge clk);
        lut_dat_we = 1'b0; pix_valid = 1'b1; pix_in = 28'h0140000;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 new entry used", 32'(res_out), 32'h0400000);

        // R12 out-of-range index
        idx_write(8'd200, 1'b0);
        chk("R12 readback zero", 32'(lut_rdata), 0);
        idx_write(8'd9, 1'b1);
        dat_write(27'h123);
        chk("R12 still zero", 32'(lut_rdata), 0);
        idx_write(8'd130, 1'b0);
        chk("R12 e130 untouched", 32'(lut_rdata), 32'(mdl[130]));

        // R13 simultaneous index and data write
        idx_write(8'd3, 1'b0);
        @(negedge clk);
        lut_idx_we = 1'b1; lut_idx_val = 8'd4; lut_dat_we = 1'b1; lut_dat_val = 27'h111;
        @(negedge clk);
        lut_idx_we = 1'b0; lut_dat_we = 1'b0;
        chk("R13 index moved", 32'(lut_rdata), 32'(mdl[4]));
        idx_write(8'd3, 1'b0);
        chk("R13 old entry kept", 32'(lut_rdata), 32'(mdl[3]));

        summary();
        $finish;
    end
endmodule